// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting timer channel. A processor reaches it through a byte-wide register port. A control byte selects the channel and either sets its counting mode or asks for a snapshot of the count. The reload value is written as two bytes, low half first and high half second. The count is read back in the same two-byte order, either from the live counter or from a frozen snapshot.

Counting does not run on every clock. It advances only on cycles where the `tick` enable is high; that enable stands for the timer base clock, nominally 1193180 Hz. Three modes are offered:

- a one-shot mode whose output rises at terminal count;
- a rate generator that reloads and gives a one-cycle pulse at each terminal count;
- a square wave that reloads and toggles its output at each terminal count.

The output level can also be read as a status byte. Settings the channel does not support raise a sticky error flag and change nothing.

Top module: `pit_channel`

## Requirements
- R1: After reset the count is 0, the output is low, the error flag is 0, and the status byte at address 2 reads 0x00.
- R2: A write to address 1 is a control byte with these fields: select in [7:6], access in [5:4], mode in [3:1] and BCD in [0]. A select value other than CHAN_ID (default 0) and other than 3 is ignored entirely.
- R3: Data writes to address 0 alternate between two targets, low byte first and then high byte. The high-byte write loads the 16-bit period and starts the countdown only when the full value is nonzero; a value of 0 leaves the channel stopped.
- R4: A low-byte write stops any countdown in progress and forces the output low.
- R5: Mode 0 (control 0x30) behaves as follows after a period of N is loaded. The output stays low for N-1 ticks and is high after the Nth tick. The count then stays at 0 and counting stops.
- R6: Mode 2 (control 0x34) raises the output for exactly one clock cycle after each Nth tick and reloads the count with N.
- R7: Mode 3 (control 0x36) toggles the output after every Nth tick and reloads the count with N.
- R8: With no latch active, data reads at address 0 alternate between the low byte and the high byte of the live count, starting with the low byte.
- R9: A latch command (access 0, for example control 0x00) works as follows:
  - It snapshots the count and resets the read order to the low byte.
  - While a snapshot is held, a further latch command is ignored.
  - Reads return the snapshot, and reading its high byte releases it.
- R10: Each of the following control bytes sets a sticky error flag and leaves the mode unchanged:
  - a select of 3 (read-back);
  - an access of 1 or 2;
  - a mode other than 0, 2 or 3;
  - a BCD bit of 1.
- R11: The status byte at address 2 reads SPKR_CODE (default 0x20) while the output is high and 0x00 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Base-rate count enable |
| addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; advances the data read order |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| out_level | output | 1 | Channel output level |
| err | output | 1 | Sticky flag for unsupported settings |

## Verification
Mode 0 is run with a table of reload values: 1, small values, values whose high byte is nonzero, and a near-terminal case. Each reload is read back partway through its countdown, which separates errors in byte order from errors in the decrement. The following are each run by directed sequences, so that pulse, toggle, snapshot and abort behaviour cannot be confused with one another:

- a zero reload and an abort by a low-byte write;
- the rate-generator and square-wave modes;
- a latch command followed by a repeated latch;
- control bytes addressed to another channel;
- each class of unsupported control byte.

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int CW = 16,
  parameter logic [1:0] CHAN_ID = 2'd0,
  parameter logic [7:0] SPKR_CODE = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       out_level,
  output logic       err
);
  localparam int HB = CW / 2;

  logic [CW-1:0] count_q, period_q, latch_q;
  logic [2:0]    mode_q;
  logic          latched_q, rd_hi_q, wr_hi_q, run_q, out_q, err_q;

  logic [1:0] f_sel, f_acc;
  logic [2:0] f_mode;
  logic       f_bcd;
  assign f_sel  = wdata[7:6];
  assign f_acc  = wdata[5:4];
  assign f_mode = wdata[3:1];
  assign f_bcd  = wdata[0];

  wire ctl_wr   = wr_en && addr == 2'd1;
  wire dat_wr   = wr_en && addr == 2'd0;
  wire dat_rd   = rd_en && addr == 2'd0;
  wire ctl_rb   = ctl_wr && f_sel == 2'd3;
  wire ctl_me   = ctl_wr && f_sel == CHAN_ID;
  wire ctl_lat  = ctl_me && f_acc == 2'd0;
  wire mode_ok  = f_mode == 3'd0 || f_mode == 3'd2 || f_mode == 3'd3;
  wire ctl_cfg  = ctl_me && f_acc == 2'd3 && mode_ok && !f_bcd;
  wire ctl_bad  = ctl_rb || (ctl_me && f_acc != 2'd0 && !(f_acc == 2'd3 && mode_ok && !f_bcd));
  wire terminal = run_q && tick && count_q == CW'(1);
  wire [CW-1:0] rd_src = latched_q ? latch_q : count_q;

  always_comb begin
    case (addr)
      2'd0:    rdata = rd_hi_q ? rd_src[CW-1:HB] : rd_src[HB-1:0];
      2'd2:    rdata = out_q ? SPKR_CODE : 8'h00;
      default: rdata = 8'h00;
    endcase
  end

  assign out_level = out_q;
  assign err = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0; period_q <= '0; latch_q <= '0; mode_q <= 3'd0;
      latched_q <= 1'b0; rd_hi_q <= 1'b0; wr_hi_q <= 1'b0;
      run_q <= 1'b0; out_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (ctl_bad) err_q <= 1'b1;
      if (ctl_cfg) mode_q <= f_mode;

      if (dat_wr && !wr_hi_q) begin
        count_q[HB-1:0] <= wdata;
        run_q <= 1'b0;
        out_q <= 1'b0;
        wr_hi_q <= 1'b1;
      end else if (dat_wr) begin
        count_q[CW-1:HB] <= wdata;
        period_q <= {wdata, count_q[HB-1:0]};
        run_q <= {wdata, count_q[HB-1:0]} != '0;
        wr_hi_q <= 1'b0;
      end else if (run_q) begin
        if (mode_q == 3'd2) out_q <= terminal;
        if (terminal) begin
          case (mode_q)
            3'd0: begin count_q <= '0; run_q <= 1'b0; out_q <= 1'b1; end
            3'd3: begin count_q <= period_q; out_q <= !out_q; end
            default: count_q <= period_q;
          endcase
        end else if (tick) begin
          count_q <= count_q - CW'(1);
        end
      end

      if (ctl_lat && !latched_q) begin
        latch_q <= count_q;
        latched_q <= 1'b1;
        rd_hi_q <= 1'b0;
      end else if (dat_rd) begin
        rd_hi_q <= !rd_hi_q;
        if (rd_hi_q) latched_q <= 1'b0;
      end
    end
  end

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n) err_q |=> err_q);
  a_r5_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_q) |-> $past(tick));
  a_r4_lowwrite_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !wr_hi_q) |=> (!run_q && !out_q));
  a_r9_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && !(dat_rd && rd_hi_q)) |=> $stable(latch_q));
  a_r3_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(count_q));
  a_r10_bad_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bad) |=> $stable(mode_q));
endmodule

// File: tb/pit_channel_test.sv
module pit_channel_test;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic out_level, err;
  int checks = 0, failures = 0, cyc = 0;

  pit_channel uut (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
                   .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .out_level(out_level), .err(err));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    addr = 2'd0; rd_en = 1; #1 d = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rd16(output int v);
    logic [7:0] lo, hi;
    rd(lo); rd(hi);
    v = {hi, lo};
  endtask

  task automatic ticks(int n);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic load(int v);
    wr(2'd0, v[7:0]); wr(2'd0, v[15:8]);
  endtask

  task automatic status(output logic [7:0] s);
    addr = 2'd2; #1 s = rdata; addr = 2'd0;
  endtask

  task automatic reset_dut();
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  localparam int NV = 5;
  localparam int VEC [NV][2] = '{'{1, 0}, '{5, 2}, '{258, 100}, '{300, 299}, '{16'h1234, 16'h1200}};

  initial begin
    int v;
    logic [7:0] s;
    reset_dut();
    chk("R1 out", out_level, 0);
    chk("R1 err", err, 0);
    status(s); chk("R1 status", s, 8'h00);
    rd16(v); chk("R1 count", v, 0);

    wr(2'd1, 8'h30);
    for (int i = 0; i < NV; i++) begin
      load(VEC[i][0]);
      ticks(VEC[i][1]);
      rd16(v); chk("R8 live read", v, VEC[i][0] - VEC[i][1]);
      ticks(VEC[i][0] - VEC[i][1] - 1);
      chk("R5 before terminal", out_level, 0);
      ticks(1);
      chk("R5 at terminal", out_level, 1);
      status(s); chk("R11 status high", s, 8'h20);
      ticks(3);
      rd16(v); chk("R5 stopped at zero", v, 0);
    end

    load(0); ticks(5);
    chk("R4 low write drops out", out_level, 0);
    status(s); chk("R11 status low", s, 8'h00);
    rd16(v); chk("R3 zero reload stays", v, 0);

    load(10); ticks(5);
    wr(2'd0, 8'h20); ticks(30);
    chk("R4 abort no terminal", out_level, 0);
    wr(2'd0, 8'h00);
    rd16(v); chk("R4 abort count held", v, 16'h0020);

    load(100); ticks(10);
    wr(2'd1, 8'h00); ticks(5);
    wr(2'd1, 8'h00);
    rd16(v); chk("R9 latch snapshot", v, 90);
    rd16(v); chk("R9 released live", v, 85);

    wr(2'd1, 8'h40);
    rd16(v); chk("R2 other channel ignored", v, 85);
    chk("R2 other channel no err", err, 0);

    wr(2'd1, 8'h34);
    load(3); ticks(3);
    chk("R6 pulse high", out_level, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", out_level, 0);
    ticks(2); chk("R6 reload low", out_level, 0);
    ticks(1); chk("R6 second pulse", out_level, 1);

    wr(2'd1, 8'h36);
    load(4); ticks(4);
    chk("R7 toggle high", out_level, 1);
    ticks(4);
    chk("R7 toggle low", out_level, 0);

    wr(2'd1, 8'h31);
    chk("R10 bcd err", err, 1);
    load(2); ticks(2); chk("R10 mode kept a", out_level, 1);
    ticks(2); chk("R10 mode kept b", out_level, 0);
    wr(2'd1, 8'h30);
    chk("R10 err sticky", err, 1);

    reset_dut(); wr(2'd1, 8'hC0); chk("R10 readback err", err, 1);
    reset_dut(); wr(2'd1, 8'h10); chk("R10 access err", err, 1);
    reset_dut(); wr(2'd1, 8'h32); chk("R10 mode err", err, 1);
    load(2); ticks(2); chk("R10 mode stays 0", out_level, 1);
    ticks(2); chk("R10 mode stays 0 b", out_level, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule